// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the data address a 24-bit-address processor core uses for one memory operand. A sequencer presents an addressing mode together with the instruction's 16-bit operand and the current X, Y, direct-page, data-bank and stack-pointer values, then pulses a start strobe. One clock later the unit holds the effective address, a second "dummy" address for the wasted bus read that hardware performs when a page boundary is crossed, and a flag telling the sequencer whether that extra cycle must be scheduled.

Once an address is held, the sequencer can step it forward or backward one byte at a time for multi-byte operands. A step only changes the 16-bit offset within the bank. The bank byte never changes.

Top module: `ea_unit`

## Requirements
- R1: After reset, `ea_o` and `dummy_o` are zero and `extra_o` and `valid_o` are low.
- R2: Outputs update on the rising edge where `start_i` is high, using `mode_i` and the operand inputs sampled at that edge. `valid_o` goes high from then on. `mode_i` encodes: 0 abs+X write, 1 abs+X read, 2 abs+Y write, 3 abs+Y read, 4 direct, 5 direct+X, 6 stack-relative, 7 stack.
- R3: Absolute indexed modes (0 to 3) give `ea_o = {dbank_i, (operand_i + index) mod 2^16}`. Modes 0 and 1 use X; modes 2 and 3 use Y.
- R4: In modes 0 to 3, `dummy_o = {dbank_i, operand_i[15:8], ea_o[7:0]}`.
- R5: Write-type modes 0 and 2 always set `extra_o`. Read-type modes 1 and 3 set it only when `dummy_o != ea_o`.
- R6: When `idx8_i` is high, X and Y are used with their upper byte forced to zero.
- R7: Mode 4 gives `ea_o = {8'h00, (dir_i + operand_i) mod 2^16}` with `dummy_o = ea_o`. Mode 5 also adds X to that sum, and gives `dummy_o = {8'h00, dir_i[15:8], ea_o[7:0]}`.
- R8: In modes 4 and 5, `extra_o` is high exactly when `dir_i[7:0]` is nonzero.
- R9: Mode 6 gives `ea_o = {8'h00, (sp_i + operand_i) mod 2^16}`, with `dummy_o = ea_o` and `extra_o` low.
- R10: Mode 7 gives `ea_o = {16'h0001, sp_i[7:0]}` when `emu_i` is high, else `{8'h00, sp_i}`. `dummy_o` equals `ea_o` and `extra_o` is low.
- R11: A `step_i` pulse without `start_i` replaces `ea_o[15:0]` with that value plus one, or minus one when `step_dn_i` is high, wrapping modulo 2^16. `ea_o[23:16]`, `dummy_o` and `extra_o` stay unchanged.
- R12: When `start_i` and `step_i` are both high, the new computation is loaded and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new address computation |
| mode_i | input | 3 | Addressing mode code |
| operand_i | input | 16 | Instruction operand |
| idx_x_i | input | 16 | X index register |
| idx_y_i | input | 16 | Y index register |
| idx8_i | input | 1 | Index registers are 8 bits wide |
| dir_i | input | 16 | Direct-page base |
| dbank_i | input | 8 | Data bank |
| sp_i | input | 16 | Stack pointer |
| emu_i | input | 1 | Emulation mode (page-one stack) |
| step_i | input | 1 | Step held address by one byte |
| step_dn_i | input | 1 | Step direction is downward |
| ea_o | output | 24 | Effective address |
| dummy_o | output | 24 | Address for the page-cross dummy read |
| extra_o | output | 1 | Extra bus cycle required |
| valid_o | output | 1 | An address has been loaded since reset |

## Verification
A fresh computation and a byte step can both be requested in the same clock cycle. In that case the computation must win, and any pending step is lost. The bench provokes this case on purpose. It first loads an address and steps it, so that the stepped value differs from what a new computation would give. It then raises `start_i` and `step_i` together with new operands, and compares the held address with the model's value for the new computation, not with the stepped one. Random runs also assert both strobes at once from time to time, and judge each such cycle the same way.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    M_ABS_X    = 3'd0,
    M_ABS_X_RD = 3'd1,
    M_ABS_Y    = 3'd2,
    M_ABS_Y_RD = 3'd3,
    M_DIR      = 3'd4,
    M_DIR_X    = 3'd5,
    M_STK_REL  = 3'd6,
    M_STK      = 3'd7
  } ea_mode_e;
endpackage

// File: rtl/ea_index_mask.sv
module ea_index_mask #(
  parameter int WORD_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic [WORD_W-1:0] idx_i,
  input  logic              narrow_i,
  output logic [WORD_W-1:0] idx_o
);
  localparam int HI_W = WORD_W - PAGE_W;
  assign idx_o = narrow_i ? {{HI_W{1'b0}}, idx_i[PAGE_W-1:0]} : idx_i;
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16,
  parameter int PAGE_W = 8
) (
  input  ea_mode_e            mode_i,
  input  logic [WORD_W-1:0]   operand_i,
  input  logic [WORD_W-1:0]   x_i,
  input  logic [WORD_W-1:0]   y_i,
  input  logic [WORD_W-1:0]   dir_i,
  input  logic [ADDR_W-WORD_W-1:0] dbank_i,
  input  logic [WORD_W-1:0]   sp_i,
  input  logic                emu_i,
  output logic [ADDR_W-1:0]   ea_o,
  output logic [ADDR_W-1:0]   dummy_o,
  output logic                extra_o
);
  localparam int BANK_W = ADDR_W - WORD_W;
  localparam int HI_W   = WORD_W - PAGE_W;
  localparam logic [BANK_W-1:0] BANK0 = '0;
  localparam logic [HI_W-1:0]   EMU_PAGE = HI_W'(1);

  logic [WORD_W-1:0] idx, abs_sum, dir_sum, srel_sum;
  logic              use_x, dir_odd;

  assign use_x    = (mode_i == M_ABS_X) || (mode_i == M_ABS_X_RD);
  assign idx      = use_x ? x_i : y_i;
  assign abs_sum  = operand_i + idx;
  assign dir_sum  = dir_i + operand_i + ((mode_i == M_DIR_X) ? x_i : '0);
  assign srel_sum = sp_i + operand_i;
  assign dir_odd  = |dir_i[PAGE_W-1:0];

  always_comb begin
    ea_o    = '0;
    dummy_o = '0;
    extra_o = 1'b0;
    unique case (mode_i)
      M_ABS_X, M_ABS_Y, M_ABS_X_RD, M_ABS_Y_RD: begin
        ea_o    = {dbank_i, abs_sum};
        dummy_o = {dbank_i, operand_i[WORD_W-1:PAGE_W], abs_sum[PAGE_W-1:0]};
        // read forms skip the dummy cycle when the page did not change
        if ((mode_i == M_ABS_X) || (mode_i == M_ABS_Y)) extra_o = 1'b1;
        else extra_o = (operand_i[WORD_W-1:PAGE_W] != abs_sum[WORD_W-1:PAGE_W]);
      end
      M_DIR: begin
        ea_o    = {BANK0, dir_sum};
        dummy_o = {BANK0, dir_sum};
        extra_o = dir_odd;
      end
      M_DIR_X: begin
        ea_o    = {BANK0, dir_sum};
        dummy_o = {BANK0, dir_i[WORD_W-1:PAGE_W], dir_sum[PAGE_W-1:0]};
        extra_o = dir_odd;
      end
      M_STK_REL: begin
        ea_o    = {BANK0, srel_sum};
        dummy_o = {BANK0, srel_sum};
      end
      M_STK: begin
        ea_o    = emu_i ? {BANK0, EMU_PAGE, sp_i[PAGE_W-1:0]} : {BANK0, sp_i};
        dummy_o = ea_o;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_stepper.sv
module ea_stepper #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              down_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [WORD_W-1:0] off;
  assign off    = down_i ? addr_i[WORD_W-1:0] - 1'b1 : addr_i[WORD_W-1:0] + 1'b1;
  assign addr_o = {addr_i[ADDR_W-1:WORD_W], off};
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16,
  parameter int PAGE_W = 8,
  localparam int BANK_W = ADDR_W - WORD_W,
  localparam int HI_W   = WORD_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [WORD_W-1:0] operand_i,
  input  logic [WORD_W-1:0] idx_x_i,
  input  logic [WORD_W-1:0] idx_y_i,
  input  logic              idx8_i,
  input  logic [WORD_W-1:0] dir_i,
  input  logic [BANK_W-1:0] dbank_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic              emu_i,
  input  logic              step_i,
  input  logic              step_dn_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] dummy_o,
  output logic              extra_o,
  output logic              valid_o
);
  ea_mode_e          mode_s;
  logic [WORD_W-1:0] idx_m [2];
  logic [WORD_W-1:0] idx_raw [2];
  logic [ADDR_W-1:0] ea_d, dummy_d, ea_stepped;
  logic              extra_d;

  assign mode_s     = ea_mode_e'(mode_i);
  assign idx_raw[0] = idx_x_i;
  assign idx_raw[1] = idx_y_i;

  for (genvar g = 0; g < 2; g++) begin : g_idx
    ea_index_mask #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_mask (
      .idx_i(idx_raw[g]), .narrow_i(idx8_i), .idx_o(idx_m[g])
    );
  end

  ea_calc #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_calc (
    .mode_i(mode_s), .operand_i(operand_i), .x_i(idx_m[0]), .y_i(idx_m[1]),
    .dir_i(dir_i), .dbank_i(dbank_i), .sp_i(sp_i), .emu_i(emu_i),
    .ea_o(ea_d), .dummy_o(dummy_d), .extra_o(extra_d)
  );

  ea_stepper #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_step (
    .addr_i(ea_o), .down_i(step_dn_i), .addr_o(ea_stepped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o    <= '0;
      dummy_o <= '0;
      extra_o <= 1'b0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      ea_o    <= ea_d;
      dummy_o <= dummy_d;
      extra_o <= extra_d;
      valid_o <= 1'b1;
    end else if (step_i) begin
      ea_o    <= ea_stepped;
    end
  end

  a_r2_valid_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  a_r5_read_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_s == M_ABS_X_RD || mode_s == M_ABS_Y_RD)) |=> (extra_o == (dummy_o != ea_o)));
  a_r7_direct_bank0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_s == M_DIR || mode_s == M_DIR_X)) |=> (ea_o[ADDR_W-1:WORD_W] == '0));
  a_r10_emu_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_s == M_STK && emu_i) |=> (ea_o[WORD_W-1:PAGE_W] == HI_W'(1) && !extra_o));
  a_r11_bank_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i) |=> (ea_o[ADDR_W-1:WORD_W] == $past(ea_o[ADDR_W-1:WORD_W])
                              && $stable(dummy_o) && $stable(extra_o)));
  a_r9_srel_no_extra: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_s == M_STK_REL) |=> (!extra_o && dummy_o == ea_o));
endmodule

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  logic        clk_i = 0, rst_ni = 0;
  logic        start_i = 0, idx8_i = 0, emu_i = 0, step_i = 0, step_dn_i = 0;
  logic [2:0]  mode_i = 0;
  logic [15:0] operand_i = 0, idx_x_i = 0, idx_y_i = 0, dir_i = 0, sp_i = 0;
  logic [7:0]  dbank_i = 0;
  logic [23:0] ea_o, dummy_o;
  logic        extra_o, valid_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [23:0] e_ea, e_dm;
  logic        e_ex;

  always #5 clk_i = ~clk_i;

  ea_unit u_ea_unit (.*);

  task automatic chk(string req, logic [48:0] act, logic [48:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model of the requirements
  task automatic model(input logic [2:0] m);
    logic [15:0] x, y, ix, s;
    x = idx8_i ? (idx_x_i & 16'h00ff) : idx_x_i;
    y = idx8_i ? (idx_y_i & 16'h00ff) : idx_y_i;
    if (m < 4) begin
      ix = (m < 2) ? x : y;
      s = operand_i + ix;
      e_ea = {dbank_i, s};
      e_dm = {dbank_i, operand_i[15:8], s[7:0]};
      e_ex = (m == 0 || m == 2) ? 1'b1 : (e_dm != e_ea);
    end else if (m < 6) begin
      s = dir_i + operand_i + (m == 5 ? x : 16'h0);
      e_ea = {8'h00, s};
      e_dm = (m == 5) ? {8'h00, dir_i[15:8], s[7:0]} : e_ea;
      e_ex = (dir_i[7:0] != 8'h00);
    end else if (m == 6) begin
      e_ea = {8'h00, sp_i + operand_i}; e_dm = e_ea; e_ex = 0;
    end else begin
      e_ea = emu_i ? {16'h0001, sp_i[7:0]} : {8'h00, sp_i}; e_dm = e_ea; e_ex = 0;
    end
  endtask

  task automatic go(string req, input logic [2:0] m, input logic [15:0] op, x, y, d,
                    input logic [7:0] b, input logic [15:0] sp, input logic n8, em, stp);
    @(negedge clk_i);
    mode_i = m; operand_i = op; idx_x_i = x; idx_y_i = y; dir_i = d;
    dbank_i = b; sp_i = sp; idx8_i = n8; emu_i = em; start_i = 1; step_i = stp;
    model(m);
    @(negedge clk_i);
    start_i = 0; step_i = 0;
    chk(req, {ea_o, dummy_o, extra_o}, {e_ea, e_dm, e_ex});
    chk("R2 valid", {48'h0, valid_o}, 49'h1);
  endtask

  task automatic stepit(string req, input logic dn);
    logic [23:0] ea0, dm0; logic ex0;
    ea0 = ea_o; dm0 = dummy_o; ex0 = extra_o;
    @(negedge clk_i);
    step_i = 1; step_dn_i = dn;
    @(negedge clk_i);
    step_i = 0;
    chk(req, {ea_o, dummy_o, extra_o},
        {ea0[23:16], dn ? ea0[15:0] - 16'h1 : ea0[15:0] + 16'h1, dm0, ex0});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    #23;
    chk("R1 reset", {ea_o, dummy_o, extra_o}, 49'h0);
    chk("R1 valid", {48'h0, valid_o}, 49'h0);
    rst_ni = 1;
    // R3 R4 R5 directed: page cross and no cross
    go("R3 abs X write no cross", 0, 16'h1210, 16'h0005, 0, 0, 8'h7e, 0, 0, 0, 0);
    go("R5 abs X read no cross", 1, 16'h1210, 16'h0005, 0, 0, 8'h7e, 0, 0, 0, 0);
    go("R4 abs Y read cross", 3, 16'h12f0, 0, 16'h0020, 0, 8'h01, 0, 0, 0, 0);
    go("R3 abs Y wrap 16", 2, 16'hfff0, 0, 16'h0020, 0, 8'h33, 0, 0, 0, 0);
    go("R6 narrow index", 1, 16'h10f0, 16'hab20, 0, 0, 8'h02, 0, 1, 0, 0);
    go("R7 direct", 4, 16'h0010, 0, 0, 16'h2000, 8'h55, 0, 0, 0, 0);
    go("R8 direct unaligned", 4, 16'hfff0, 0, 0, 16'h0021, 8'h55, 0, 0, 0, 0);
    go("R7 direct X", 5, 16'h00f0, 16'h0030, 0, 16'h3001, 8'h55, 0, 0, 0, 0);
    go("R9 stack rel wrap", 6, 16'h0010, 0, 0, 0, 8'h44, 16'hfff8, 0, 0, 0);
    go("R10 stack emu", 7, 0, 0, 0, 0, 8'h44, 16'h1fe3, 0, 1, 0);
    go("R10 stack native", 7, 0, 0, 0, 0, 8'h44, 16'h1fe3, 0, 0, 0);
    // R11 steps and wrap inside bank
    go("R3 setup", 0, 16'hfffe, 16'h0001, 0, 0, 8'h9a, 0, 0, 0, 0);
    stepit("R11 step up wrap", 0);
    stepit("R11 step down wrap", 1);
    stepit("R11 step down", 1);
    // R12 simultaneous start and step
    go("R12 start beats step", 2, 16'h4000, 0, 16'h0003, 0, 8'h10, 0, 0, 0, 1);
    for (int i = 0; i < 400; i++) begin
      go("R2 random", 3'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
         ($urandom % 3 == 0) ? 16'($urandom) & 16'hff00 : 16'($urandom),
         8'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4 == 0));
      if ($urandom % 3 == 0) stepit("R11 random", 1'($urandom));
    end
    finish_run();
  end
endmodule